// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects a synchronous load/store request port to an external parallel memory bus that is treated as asynchronous. On the bus, the low address byte and the data byte share one 8-bit lane. The high address byte has its own port and is held for the whole access. An address latch enable (ALE) strobe lets the external device capture the low byte. Active-low read and write strobes then move the data. All bus timing comes from the internal clock, and no phase relationship to any external clock is assumed.

A programmable boundary address splits the external space into a lower and an upper sector. Each sector has its own 2-bit wait-state code, and the sector of the access address picks which code applies. The code sets how long the strobe stays active. The largest code also adds an idle cycle before the next address goes out. The shared lane is exposed as separate pad-side signals: value, output enable and input. An optional keeper holds the last lane value while the lane is not otherwise in use. The CPU side raises a request and receives a one-cycle ready pulse. A hint input tells the block whether the following operation also targets RAM, and this decides whether ALE pulses in the last cycle of an access.

Top module: `xmem_bridge`

## Requirements
- R1: While reset is held and after it is released, the bus is idle: ALE low, both strobes high, ready low, and the lane not driven while the keeper is off.
- R2: A request accepted when the block is idle causes exactly one ALE-high cycle, one clock after acceptance. In that cycle the lane drives the low address byte. `bus_ahi` carries the high address byte in every cycle from ALE until ready.
- R3: An address greater than or equal to `cfg_limit` uses `cfg_wait_hi`. An address below `cfg_limit` uses `cfg_wait_lo`.
- R4: The strobe is low for 1 clock cycle with wait code 0, 2 cycles with code 1, and 3 cycles with codes 2 and 3.
- R5: Ready is high for one cycle, the cycle after the last strobe cycle. If a new request is already present in that cycle, its ALE follows 2 clocks after ready. After an access that used code 3, the ALE follows 3 clocks after ready.
- R6: A write drives the write data on the lane from the first strobe cycle through the ready cycle. `bus_rd_n` stays high during a write. The data lands at the latched address.
- R7: A read releases the lane while `bus_rd_n` is low and keeps `bus_wr_n` high. It captures the lane value at the end of the last strobe cycle and presents it on `req_rdata` in the ready cycle.
- R8: In the ready cycle, ALE equals the `next_is_ram` input.
- R9: With the keeper enabled, the idle lane is driven with the last value the block put on it or captured from it: the address, the write data or the read data. With the keeper disabled, the idle lane is released.
- R10: The two strobes are never low together, and ALE is never high while a strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_limit | input | 16 | First address of the upper sector |
| cfg_wait_lo | input | 2 | Wait-state code for the lower sector |
| cfg_wait_hi | input | 2 | Wait-state code for the upper sector |
| cfg_keeper | input | 1 | Lane keeper enable |
| req_valid | input | 1 | Access request, held until ready |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| next_is_ram | input | 1 | The following operation is a RAM access |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Read data, valid with ready |
| bus_ahi | output | 8 | High address byte |
| bus_ad_out | output | 8 | Shared lane output value |
| bus_ad_oe | output | 1 | Shared lane output enable |
| bus_ad_in | input | 8 | Shared lane input value |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
The bench sweeps all sixteen pairs of lower and upper wait codes. In each pair it issues back-to-back writes and then back-to-back reads, one in each sector, against a latch-based memory model. Strobe widths that differ by sector show whether the sector selection works. Chained requests separate code 3 from code 2 through the gap before the next ALE. Reading back after writes into both sectors shows whether the latched address and the lane turnaround are right. The keeper setting alternates across the sweep, and the trailing ALE hint alternates between accesses. A final pair of accesses on either side of a moved boundary checks the greater-or-equal comparison exactly at the limit.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

  localparam int WCW = 2;  // wait code width
  localparam int SCW = 2;  // stretch counter width

  typedef logic [WCW-1:0] wcode_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_STRB,
    PH_DONE,
    PH_GAP
  } phase_t;

  // extra strobe cycles beyond the basic one
  function automatic logic [SCW-1:0] stretch_of(wcode_t c);
    case (c)
      2'b00:   stretch_of = 2'd0;
      2'b01:   stretch_of = 2'd1;
      default: stretch_of = 2'd2;
    endcase
  endfunction

  // idle cycle before the next address phase
  function automatic logic gap_of(wcode_t c);
    gap_of = (c == 2'b11);
  endfunction

endpackage

// File: rtl/xmb_sector.sv
module xmb_sector
  import xmb_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] limit,
  input  wcode_t        code_lo,
  input  wcode_t        code_hi,
  output wcode_t        code_sel,
  output logic          upper
);

  always_comb begin
    upper    = (addr >= limit);
    code_sel = upper ? code_hi : code_lo;
  end

endmodule

// File: rtl/xmb_stretch.sv
module xmb_stretch #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          zero
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (run && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/xmb_lane.sv
module xmb_lane #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [DW-1:0] set_val,
  input  logic          drive,
  input  logic          keeper,
  input  logic          keep_ok,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe
);

  logic [DW-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (set_en) hold_d = set_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign ad_out = hold_q;
  assign ad_oe  = drive | (keeper & keep_ok);

endmodule

// File: rtl/xmem_bridge.sv
module xmem_bridge
  import xmb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_limit,
  input  logic [1:0]    cfg_wait_lo,
  input  logic [1:0]    cfg_wait_hi,
  input  logic          cfg_keeper,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          next_is_ram,
  output logic          req_ready,
  output logic [DW-1:0] req_rdata,
  output logic [AW-DW-1:0] bus_ahi,
  output logic [DW-1:0] bus_ad_out,
  output logic          bus_ad_oe,
  input  logic [DW-1:0] bus_ad_in,
  output logic          bus_ale,
  output logic          bus_rd_n,
  output logic          bus_wr_n
);

  localparam int HW = AW - DW;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // state
  phase_t        ph_q, ph_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          we_q;
  wcode_t        code_q;

  wcode_t        code_sel;
  logic          upper;
  logic          t_zero;
  logic          accept, strb_last;
  logic          lane_set;
  logic [DW-1:0] lane_val;
  logic          lane_drive, lane_keep_ok;

  xmb_sector #(.AW(AW)) u_sector (
    .addr     (req_addr),
    .limit    (cfg_limit),
    .code_lo  (cfg_wait_lo),
    .code_hi  (cfg_wait_hi),
    .code_sel (code_sel),
    .upper    (upper)
  );

  xmb_stretch #(.CW(SCW)) u_stretch (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (ph_q == PH_ADDR),
    .load_val (stretch_of(code_q)),
    .run      (ph_q == PH_STRB),
    .zero     (t_zero)
  );

  assign accept    = (ph_q == PH_IDLE) && req_valid;
  assign strb_last = (ph_q == PH_STRB) && t_zero;

  // next-state
  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE: if (req_valid) ph_d = PH_ADDR;
      PH_ADDR: ph_d = PH_STRB;
      PH_STRB: if (t_zero) ph_d = PH_DONE;
      PH_DONE: ph_d = gap_of(code_q) ? PH_GAP : PH_IDLE;
      PH_GAP:  ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_IDLE;
    else         ph_q <= ph_d;
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      code_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      we_q    <= req_we;
      code_q  <= code_sel;
    end
  end

  // read data, enabled at end of a read strobe
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                 rdata_q <= '0;
    else if (strb_last && !we_q) rdata_q <= bus_ad_in;
  end

  // lane value selection
  always_comb begin
    lane_set = 1'b0;
    lane_val = req_addr[DW-1:0];
    if (accept) begin
      lane_set = 1'b1;
      lane_val = req_addr[DW-1:0];
    end else if ((ph_q == PH_ADDR) && we_q) begin
      lane_set = 1'b1;
      lane_val = wdata_q;
    end else if (strb_last && !we_q) begin
      lane_set = 1'b1;
      lane_val = bus_ad_in;
    end
  end

  assign lane_drive   = (ph_q == PH_ADDR) ||
                        (we_q && ((ph_q == PH_STRB) || (ph_q == PH_DONE)));
  assign lane_keep_ok = (ph_q == PH_IDLE) || (ph_q == PH_GAP) ||
                        ((ph_q == PH_DONE) && !we_q);

  xmb_lane #(.DW(DW)) u_lane (
    .clk     (clk),
    .rst_n   (rst_ni),
    .set_en  (lane_set),
    .set_val (lane_val),
    .drive   (lane_drive),
    .keeper  (cfg_keeper),
    .keep_ok (lane_keep_ok),
    .ad_out  (bus_ad_out),
    .ad_oe   (bus_ad_oe)
  );

  // bus strobes
  assign bus_ahi   = addr_q[AW-1:DW];
  assign bus_ale   = (ph_q == PH_ADDR) || ((ph_q == PH_DONE) && next_is_ram);
  assign bus_rd_n  = !((ph_q == PH_STRB) && !we_q);
  assign bus_wr_n  = !((ph_q == PH_STRB) && we_q);
  assign req_ready = (ph_q == PH_DONE);
  assign req_rdata = rdata_q;

  // R10
  assert property (@(posedge clk) disable iff (!rst_ni)
    bus_ale |-> (bus_rd_n && bus_wr_n))
    else $error("ale_strobe_overlap_chk");

  // R10
  assert property (@(posedge clk) disable iff (!rst_ni)
    !(!bus_rd_n && !bus_wr_n))
    else $error("strobe_excl_chk");

  // R5
  assert property (@(posedge clk) disable iff (!rst_ni)
    req_ready |=> !req_ready)
    else $error("ready_single_chk");

  // R4
  assert property (@(posedge clk) disable iff (!rst_ni)
    req_ready |-> $past(!bus_rd_n || !bus_wr_n))
    else $error("ready_after_strobe_chk");

  // R7
  assert property (@(posedge clk) disable iff (!rst_ni)
    !bus_rd_n |-> !bus_ad_oe)
    else $error("read_lane_release_chk");

  // R2
  assert property (@(posedge clk) disable iff (!rst_ni)
    (!bus_rd_n || !bus_wr_n) |-> $stable(bus_ahi))
    else $error("ahi_stable_chk");

  logic [HW-1:0] unused_hw;
  assign unused_hw = '0;
  logic unused_upper;
  assign unused_upper = upper;

endmodule

// File: tb/sim_xmem_bridge.sv
module sim_xmem_bridge;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_limit;
  logic [1:0]  cfg_wait_lo, cfg_wait_hi;
  logic        cfg_keeper;
  logic        req_valid, req_we, next_is_ram;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready;
  logic [7:0]  req_rdata;
  logic [7:0]  bus_ahi, bus_ad_out, lane;
  logic        bus_ad_oe, bus_ale, bus_rd_n, bus_wr_n;

  always #10 clk = ~clk;

  xmem_bridge u0 (
    .clk(clk), .rst_n(rst_n), .cfg_limit(cfg_limit),
    .cfg_wait_lo(cfg_wait_lo), .cfg_wait_hi(cfg_wait_hi), .cfg_keeper(cfg_keeper),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .next_is_ram(next_is_ram),
    .req_ready(req_ready), .req_rdata(req_rdata), .bus_ahi(bus_ahi),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(lane),
    .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
  );

  // ALE-latched memory model
  logic [7:0]  mem [256];
  logic [15:0] lat;

  function automatic logic [7:0] idx(logic [15:0] a);
    return {a[15], a[6:0]};
  endfunction

  always_comb lane = bus_ad_oe ? bus_ad_out : (!bus_rd_n ? mem[idx(lat)] : 8'h00);

  always @(posedge clk) begin
    if (bus_ale)   lat <= {bus_ahi, lane};
    if (!bus_wr_n) mem[idx(lat)] <= lane;
  end

  int ncyc = 0;
  always @(posedge clk) ncyc <= ncyc + 1;

  int ntests = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_stb(logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 3;
  endfunction

  function automatic int exp_gap(logic [1:0] c);
    return (c == 2'd3) ? 3 : 2;
  endfunction

  bit         chain = 0;
  logic [1:0] prev_code;
  int         t_ready;

  task automatic access(input logic we, input logic [15:0] a, input logic [7:0] wd,
                        input logic nram, input logic [1:0] code, output logic [7:0] rd);
    int  stb = 0;
    int  guard = 0;
    bit  seen_ale = 0;
    bit  ahi_ok = 1, excl_ok = 1, dir_ok = 1, wlane_ok = 1;
    bit  got = 0;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd; next_is_ram = nram;
    while (!got && guard < 20) begin
      @(negedge clk);
      guard++;
      if (bus_ale && !seen_ale && !req_ready) begin
        seen_ale = 1;
        chk(bus_ad_oe && bus_ad_out == a[7:0], "R2 address on lane", bus_ad_out, a[7:0]);
        if (chain)
          chk(ncyc - t_ready == exp_gap(prev_code), "R5 ready-to-ALE gap",
              ncyc - t_ready, exp_gap(prev_code));
      end
      if (seen_ale && bus_ahi != a[15:8]) ahi_ok = 0;
      if (!bus_rd_n && !bus_wr_n) excl_ok = 0;
      if (bus_ale && (!bus_rd_n || !bus_wr_n)) excl_ok = 0;
      if (!bus_rd_n || !bus_wr_n) begin
        stb++;
        if (we && !bus_rd_n) dir_ok = 0;
        if (!we && (!bus_wr_n || bus_ad_oe)) dir_ok = 0;
        if (we && !(bus_ad_oe && bus_ad_out == wd)) wlane_ok = 0;
      end
      if (req_ready) begin
        got = 1;
        if (we && !(bus_ad_oe && bus_ad_out == wd)) wlane_ok = 0;
        chk(bus_ale == nram, "R8 trailing ALE", bus_ale, nram);
        rd = req_rdata;
      end
    end
    chk(got, "R5 ready seen", got, 1);
    chk(stb == exp_stb(code), "R4/R3 strobe width", stb, exp_stb(code));
    chk(ahi_ok, "R2 high address held", ahi_ok, 1);
    chk(excl_ok, "R10 strobe exclusivity", excl_ok, 1);
    chk(dir_ok, we ? "R6 write direction" : "R7 read direction", dir_ok, 1);
    if (we) chk(wlane_ok, "R6 write data on lane", wlane_ok, 1);
    t_ready   = ncyc;
    prev_code = code;
    chain     = 1;
  endtask

  task automatic go_idle();
    req_valid = 1'b0;
    @(negedge clk);
    chain = 0;
  endtask

  task automatic keeper_chk(input logic [7:0] last);
    if (cfg_keeper)
      chk(bus_ad_oe && bus_ad_out == last, "R9 keeper holds value", bus_ad_out, last);
    else
      chk(!bus_ad_oe, "R9 lane released", bus_ad_oe, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      ntests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rst_n = 1'b0; cfg_limit = 16'h8000; cfg_wait_lo = 2'd0; cfg_wait_hi = 2'd0;
    cfg_keeper = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0;
    req_wdata = '0; next_is_ram = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(!bus_ale && bus_rd_n && bus_wr_n && !req_ready && !bus_ad_oe,
        "R1 reset idle", {bus_ale, bus_rd_n, bus_wr_n, req_ready, bus_ad_oe}, 5'b01100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bus_ale && bus_rd_n && bus_wr_n && !req_ready && !bus_ad_oe,
        "R1 idle after release", {bus_ale, bus_rd_n, bus_wr_n, req_ready, bus_ad_oe}, 5'b01100);

    // sweep of all wait code pairs (R3, R4, R5)
    for (int c = 0; c < 16; c++) begin
      logic [1:0]  clo, chi;
      logic [15:0] alo, ahi;
      logic [7:0]  dlo, dhi;
      clo = c[1:0]; chi = c[3:2];
      cfg_wait_lo = clo; cfg_wait_hi = chi;
      cfg_keeper  = c[0] ^ c[3];
      alo = 16'h0100 + 16'(c);
      ahi = 16'h8100 + 16'(c);
      dlo = 8'(c * 7 + 3);
      dhi = 8'(c * 13 + 5);
      access(1'b1, alo, dlo, 1'b1, clo, rd);
      access(1'b1, ahi, dhi, 1'b0, chi, rd);
      go_idle();
      keeper_chk(dhi);
      access(1'b0, alo, 8'h00, 1'b0, clo, rd);
      chk(rd == dlo, "R6/R7 lower sector data", rd, dlo);
      access(1'b0, ahi, 8'h00, 1'b1, chi, rd);
      chk(rd == dhi, "R6/R7 upper sector data", rd, dhi);
      go_idle();
      keeper_chk(dhi);
      repeat (2) @(negedge clk);
    end

    // boundary at a moved limit (R3)
    cfg_limit = 16'h1234; cfg_wait_lo = 2'd0; cfg_wait_hi = 2'd3; cfg_keeper = 1'b1;
    access(1'b1, 16'h1233, 8'hA5, 1'b0, 2'd0, rd);
    access(1'b1, 16'h1234, 8'h5A, 1'b0, 2'd3, rd);
    go_idle();
    access(1'b0, 16'h1233, 8'h00, 1'b0, 2'd0, rd);
    chk(rd == 8'hA5, "R3 below limit data", rd, 8'hA5);
    access(1'b0, 16'h1234, 8'h00, 1'b0, 2'd3, rd);
    chk(rd == 8'h5A, "R3 at limit data", rd, 8'h5A);
    go_idle();
    keeper_chk(8'h5A);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule